// File: doc/BRIEF.md
# Two-Phase Cascaded Duty Controller with Current Sharing

This block is the sampled control law for a two-phase interleaved boost stage. Each sample strobe delivers four signed words: a voltage reference, the output voltage, the phase-1 inductor current and the phase-2 inductor current. The output voltage comes through a divider of gain k, and the reference is given in the same scaled units. From these words the block computes one duty word per phase. The downstream PWM generator runs the phase-2 carrier half a period (180 degrees) behind phase 1. This block only supplies the two numbers.

The two phases are controlled differently. Phase 1 carries the regulation. An outer PI loop acts on the voltage error, and its clamped output is the current demand for an inner PI loop on the phase-1 current. Phase 2 does not see the voltage at all. Its PI loop tracks half the sum of both phase currents, so its error equals half the difference between the phase-1 and phase-2 currents, and the two phases end up carrying the same current.

All gains are Q-format words with FRAC fractional bits. One magnitude limit clamps every integrator and the current demand. The duty words are clamped to a programmable window.

Top module: `dual_phase_share_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge (synchronous reset), every integrator is cleared, duty_valid is driven low, and both duty outputs are loaded with duty_min.
- R2: duty_valid is a one-cycle pulse that is high after the second clock edge following the edge that samples smp_valid high. Between pulses, duty1 and duty2 hold their values.
- R3: The voltage error is v_ref − v_out. The outer PI output, clamped to ±int_lim, is the phase-1 current demand.
- R4: The phase-1 error is the current demand minus i_ph1, and the phase-1 PI output sets duty1.
- R5: The phase-2 error is ((i_ph1 + i_ph2) >>> 1) − i_ph2. The sum is formed without loss of bits, and the shift is arithmetic, so it rounds toward minus infinity. For example, i_ph1 = −3 and i_ph2 = −100 give an error of 48.
- R6: Each PI stage computes p = (kp·e) >>> FRAC and I' = I + ((ki·e) >>> FRAC), then clamps I' to ±int_lim, stores it and outputs p + I'. Both shifts are arithmetic.
- R7: Each duty output is the PI output clamped to [duty_min, duty_max], with duty_min ≤ duty_max.
- R8: The integrator clamp prevents windup. After the error reverses, the output drops from the clamped value at once, with no excess to unwind first.
- R9: duty2 depends only on the two phase currents and never on v_ref or v_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | New sample strobe |
| v_ref | input | DW | Voltage reference, signed, in divider-scaled units |
| v_out | input | DW | Sensed output voltage, signed |
| i_ph1 | input | DW | Phase-1 current sample, signed |
| i_ph2 | input | DW | Phase-2 current sample, signed |
| kp_v | input | GW | Voltage loop proportional gain, signed Q |
| ki_v | input | GW | Voltage loop integral gain, signed Q |
| kp_c1 | input | GW | Phase-1 current loop proportional gain |
| ki_c1 | input | GW | Phase-1 current loop integral gain |
| kp_c2 | input | GW | Phase-2 sharing loop proportional gain |
| ki_c2 | input | GW | Phase-2 sharing loop integral gain |
| int_lim | input | DW | Unsigned magnitude limit for integrators and current demand |
| duty_min | input | DTW | Lower duty bound |
| duty_max | input | DTW | Upper duty bound |
| duty1 | output | DTW | Phase-1 duty word |
| duty2 | output | DTW | Phase-2 duty word |
| duty_valid | output | 1 | Pulse marking fresh duty words |

## Verification
Proportional-only runs with several current pairs show whether the voltage and current errors have the right sign and whether each phase sees the right error. Odd current sums of both signs tell an arithmetic floor shift apart from truncation toward zero. Repeated samples with integral gain only show whether the integrators accumulate correctly. A long saturating run followed by a reversed error separates a clamped integrator from one that has wound up. A sweep of v_ref with the currents held fixed shows whether phase 2 is independent of the voltage loop, and large errors drive both duty bounds.

// File: rtl/dual_phase_share_ctrl.sv
module dual_phase_share_ctrl #(
  parameter int DW   = 16,
  parameter int GW   = 16,
  parameter int FRAC = 8,
  parameter int DTW  = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_valid,
  input  logic signed [DW-1:0]  v_ref,
  input  logic signed [DW-1:0]  v_out,
  input  logic signed [DW-1:0]  i_ph1,
  input  logic signed [DW-1:0]  i_ph2,
  input  logic signed [GW-1:0]  kp_v,
  input  logic signed [GW-1:0]  ki_v,
  input  logic signed [GW-1:0]  kp_c1,
  input  logic signed [GW-1:0]  ki_c1,
  input  logic signed [GW-1:0]  kp_c2,
  input  logic signed [GW-1:0]  ki_c2,
  input  logic [DW-1:0]         int_lim,
  input  logic [DTW-1:0]        duty_min,
  input  logic [DTW-1:0]        duty_max,
  output logic [DTW-1:0]        duty1,
  output logic [DTW-1:0]        duty2,
  output logic                  duty_valid
);
  localparam int EW = DW + 2;
  localparam int W  = EW + GW + 2;

  function automatic logic signed [W-1:0] mulq(input logic signed [W-1:0] e,
                                               input logic signed [GW-1:0] k);
    logic signed [W-1:0] pr;
    pr = e * k;
    return pr >>> FRAC;
  endfunction

  function automatic logic signed [W-1:0] clamp(input logic signed [W-1:0] x,
                                                input logic signed [W-1:0] lim);
    if (x > lim)       return lim;
    else if (x < -lim) return -lim;
    else               return x;
  endfunction

  function automatic logic [DTW-1:0] sat_duty(input logic signed [W-1:0] x,
                                              input logic [DTW-1:0] lo,
                                              input logic [DTW-1:0] hi);
    if (x > $signed({{(W-DTW){1'b0}}, hi}))      return hi;
    else if (x < $signed({{(W-DTW){1'b0}}, lo})) return lo;
    else                                         return x[DTW-1:0];
  endfunction

  logic signed [W-1:0] limw;
  assign limw = W'($signed({1'b0, int_lim}));

  // stage 0: error formation
  logic signed [EW-1:0] ev_c, isum_c, e2_c;
  assign ev_c   = EW'(v_ref) - EW'(v_out);
  assign isum_c = EW'(i_ph1) + EW'(i_ph2);
  assign e2_c   = (isum_c >>> 1) - EW'(i_ph2);

  logic                s0_v, s1_v;
  logic signed [W-1:0] ev_q, e2_q, i1a_q, i1b_q;
  logic signed [W-1:0] integ_v, integ_1, integ_2;
  logic signed [W-1:0] ref_q;
  logic [DTW-1:0]      d2_q;

  // stage 1: voltage loop and sharing loop
  logic signed [W-1:0] iv_n, ref_c, i2_n;
  logic [DTW-1:0]      d2_c;
  assign iv_n  = clamp(integ_v + mulq(ev_q, ki_v), limw);
  assign ref_c = clamp(mulq(ev_q, kp_v) + iv_n, limw);
  assign i2_n  = clamp(integ_2 + mulq(e2_q, ki_c2), limw);
  assign d2_c  = sat_duty(mulq(e2_q, kp_c2) + i2_n, duty_min, duty_max);

  // stage 2: phase-1 current loop
  logic signed [W-1:0] e1_c, i1_n;
  logic [DTW-1:0]      d1_c;
  assign e1_c = ref_q - i1b_q;
  assign i1_n = clamp(integ_1 + mulq(e1_c, ki_c1), limw);
  assign d1_c = sat_duty(mulq(e1_c, kp_c1) + i1_n, duty_min, duty_max);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s0_v       <= 1'b0;
      s1_v       <= 1'b0;
      ev_q       <= '0;
      e2_q       <= '0;
      i1a_q      <= '0;
      i1b_q      <= '0;
      ref_q      <= '0;
      d2_q       <= '0;
      integ_v    <= '0;
      integ_1    <= '0;
      integ_2    <= '0;
      duty1      <= duty_min;
      duty2      <= duty_min;
      duty_valid <= 1'b0;
    end else begin
      s0_v       <= smp_valid;
      s1_v       <= s0_v;
      duty_valid <= s1_v;
      if (smp_valid) begin
        ev_q  <= W'(ev_c);
        e2_q  <= W'(e2_c);
        i1a_q <= W'(i_ph1);
      end
      if (s0_v) begin
        integ_v <= iv_n;
        integ_2 <= i2_n;
        ref_q   <= ref_c;
        d2_q    <= d2_c;
        i1b_q   <= i1a_q;
      end
      if (s1_v) begin
        integ_1 <= i1_n;
        duty1   <= d1_c;
        duty2   <= d2_q;
      end
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (!duty_valid && integ_v == '0 && integ_1 == '0 && integ_2 == '0
                && duty1 == $past(duty_min) && duty2 == $past(duty_min)));

  a_r2_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
    duty_valid |-> $past(smp_valid, 3));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!duty_valid && $past(rst_n)) |-> ($stable(duty1) && $stable(duty2)));

  a_r7_duty_window: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_valid && duty_min <= duty_max) |->
      (duty1 >= duty_min && duty1 <= duty_max && duty2 >= duty_min && duty2 <= duty_max));

  a_r8_integ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(s0_v) && $past(rst_n)) |->
      (integ_v <= W'($signed({1'b0, $past(int_lim)})) &&
       integ_v >= -W'($signed({1'b0, $past(int_lim)})) &&
       integ_2 <= W'($signed({1'b0, $past(int_lim)})) &&
       integ_2 >= -W'($signed({1'b0, $past(int_lim)}))));

  a_r3_demand_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(s0_v) && $past(rst_n)) |->
      (ref_q <= W'($signed({1'b0, $past(int_lim)})) &&
       ref_q >= -W'($signed({1'b0, $past(int_lim)}))));
endmodule

// File: tb/tb_dual_phase_share_ctrl.sv
module tb_dual_phase_share_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int FRAC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [15:0] v_ref = '0, v_out = '0, i_ph1 = '0, i_ph2 = '0;
  logic signed [15:0] kp_v = '0, ki_v = '0, kp_c1 = '0, ki_c1 = '0, kp_c2 = '0, ki_c2 = '0;
  logic [15:0] int_lim = 16'd4000;
  logic [11:0] duty_min = 12'd100, duty_max = 12'd3000;
  logic [11:0] duty1, duty2;
  logic duty_valid;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  longint m_v, m_1, m_2;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_phase_share_ctrl dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .v_ref(v_ref), .v_out(v_out), .i_ph1(i_ph1), .i_ph2(i_ph2),
    .kp_v(kp_v), .ki_v(ki_v), .kp_c1(kp_c1), .ki_c1(ki_c1),
    .kp_c2(kp_c2), .ki_c2(ki_c2), .int_lim(int_lim),
    .duty_min(duty_min), .duty_max(duty_max),
    .duty1(duty1), .duty2(duty2), .duty_valid(duty_valid)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint mq(input longint e, input longint k);
    return (e * k) >>> FRAC;
  endfunction

  function automatic longint lim2(input longint x, input longint l);
    if (x > l) return l;
    if (x < -l) return -l;
    return x;
  endfunction

  function automatic longint dsat(input longint x);
    if (x > longint'(duty_max)) return longint'(duty_max);
    if (x < longint'(duty_min)) return longint'(duty_min);
    return x;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_v = 0; m_1 = 0; m_2 = 0;
    chk(duty1 == duty_min, "R1 duty1 after reset", duty1, duty_min);
    chk(duty2 == duty_min, "R1 duty2 after reset", duty2, duty_min);
    chk(duty_valid == 1'b0, "R1 valid after reset", duty_valid, 0);
  endtask

  task automatic do_sample(input int vr, input int vo, input int a, input int b,
                           input string req, output longint e1o, output longint e2o);
    longint ev, e2, e1, dem, d1, d2, l;
    @(negedge clk);
    v_ref = 16'(vr); v_out = 16'(vo); i_ph1 = 16'(a); i_ph2 = 16'(b);
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    chk(duty_valid == 1'b0, "R2 no early valid", duty_valid, 0);
    @(negedge clk);
    chk(duty_valid == 1'b0, "R2 no early valid", duty_valid, 0);
    l   = longint'(int_lim);
    ev  = longint'(vr) - longint'(vo);
    e2  = ((longint'(a) + longint'(b)) >>> 1) - longint'(b);
    m_v = lim2(m_v + mq(ev, kp_v * 0 + ki_v), l);
    dem = lim2(mq(ev, kp_v) + m_v, l);
    m_2 = lim2(m_2 + mq(e2, ki_c2), l);
    d2  = dsat(mq(e2, kp_c2) + m_2);
    e1  = dem - longint'(a);
    m_1 = lim2(m_1 + mq(e1, ki_c1), l);
    d1  = dsat(mq(e1, kp_c1) + m_1);
    @(negedge clk);
    chk(duty_valid == 1'b1, "R2 valid pulse", duty_valid, 1);
    chk(duty1 == 12'(d1), {req, " duty1"}, duty1, d1);
    chk(duty2 == 12'(d2), {req, " duty2"}, duty2, d2);
    @(negedge clk);
    chk(duty_valid == 1'b0, "R2 single-cycle pulse", duty_valid, 0);
    chk(duty1 == 12'(d1) && duty2 == 12'(d2), "R2 hold between pulses", duty1, d1);
    e1o = d1; e2o = d2;
  endtask

  task automatic set_gains(input int a, input int b, input int c, input int d,
                           input int e, input int f);
    kp_v = 16'(a); ki_v = 16'(b); kp_c1 = 16'(c); ki_c1 = 16'(d); kp_c2 = 16'(e); ki_c2 = 16'(f);
  endtask

  task automatic t_proportional();
    longint d1, d2;
    set_gains(256, 0, 256, 0, 256, 0);
    duty_min = 12'd100; duty_max = 12'd3000; int_lim = 16'd4000;
    do_reset();
    do_sample(1000, 400, 100, 300, "R3 R4", d1, d2);
    chk(d1 == 500, "R4 demand 600 minus 100", d1, 500);
    do_sample(1500, 400, 900, 100, "R3 R5", d1, d2);
    chk(d1 == 200 && d2 == 400, "R5 share error 400", d2, 400);
    do_sample(400, 1000, 0, 0, "R3 negative error", d1, d2);
    chk(d1 == 100, "R7 low clamp", d1, 100);
  endtask

  task automatic t_odd_sums();
    longint d1, d2;
    set_gains(0, 0, 0, 0, 256, 0);
    duty_min = 12'd0; duty_max = 12'd3000;
    do_reset();
    do_sample(0, 0, 103, 0, "R5 positive odd", d1, d2);
    chk(d2 == 51, "R5 floor of 103/2", d2, 51);
    do_sample(0, 0, -3, -100, "R5 negative odd", d1, d2);
    chk(d2 == 48, "R5 floor of -103/2", d2, 48);
  endtask

  task automatic t_integral();
    longint d1, d2;
    set_gains(0, 64, 256, 0, 0, 128);
    duty_min = 12'd0; duty_max = 12'd3000; int_lim = 16'd4000;
    do_reset();
    for (int n = 1; n <= 4; n++) begin
      do_sample(600, 200, 40, 0, "R6 accumulate", d1, d2);
      chk(d1 == longint'(100 * n) - 40, "R6 voltage integral step", d1, 100 * n - 40);
    end
  endtask

  task automatic t_windup();
    longint d1, d2;
    set_gains(0, 256, 256, 0, 0, 0);
    duty_min = 12'd0; duty_max = 12'd3000; int_lim = 16'd200;
    do_reset();
    for (int n = 0; n < 5; n++) do_sample(100, 0, 0, 0, "R8 saturate", d1, d2);
    chk(d1 == 200, "R8 clamped demand", d1, 200);
    do_sample(0, 100, 0, 0, "R8 reverse", d1, d2);
    chk(d1 == 100, "R8 immediate recovery", d1, 100);
    int_lim = 16'd4000;
  endtask

  task automatic t_high_sat();
    longint d1, d2;
    set_gains(256, 0, 512, 0, 256, 0);
    duty_min = 12'd100; duty_max = 12'd3000; int_lim = 16'd30000;
    do_reset();
    do_sample(20000, 0, 0, -8000, "R7 high", d1, d2);
    chk(d1 == 3000 && d2 == 3000, "R7 upper clamp", d1, 3000);
    int_lim = 16'd4000;
  endtask

  task automatic t_independence();
    longint d1, d2, first;
    set_gains(256, 32, 256, 16, 256, 64);
    duty_min = 12'd0; duty_max = 12'd3000;
    do_reset();
    do_sample(500, 100, 800, 200, "R9 base", d1, d2);
    first = d2;
    do_reset();
    do_sample(3000, -2000, 800, 200, "R9 swept v_ref", d1, d2);
    chk(d2 == first, "R9 duty2 unaffected by voltage", d2, first);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    do_reset();
    t_proportional();
    t_odd_sums();
    t_integral();
    t_windup();
    t_high_sat();
    t_independence();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule